// File: doc/BRIEF.md
# UART Receive Queue with Interrupt Trigger

This block is the buffer that sits between a UART's serial deserializer and the register interface that the processor reads. Each received character is stored as a wide word together with an optional line-break marker. Words are kept in a circular store that is addressed by a read position and an occupancy count. One word leaves the store for each read of the data register. Software reads the current head word on `pop_word` while `pop_req` is high, and the pointers move on at the next clock edge.

A mode input chooses between two capacities. In the first the store holds only one word, like a single holding register. In the second it uses its whole depth. The block produces the empty and full status flags and a level-sensitive receive interrupt. The interrupt rises when a push brings the occupancy to exactly a programmable trigger count. It falls only when a plain pop brings the occupancy to one below that count. The deserializer uses `can_accept` to decide whether a new character can be delivered.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the occupancy and read position are zero, `empty` is 1, `full` is 0, `rx_irq` is 0 and `can_accept` is 1.
- R2: `can_accept` is 1 only while the occupancy is below DEPTH (16) with `fifo_en`=1, or below 1 with `fifo_en`=0. A push made while `can_accept` is 0 is dropped and the contents are left unchanged.
- R3: Pops return words in arrival order. Successive words occupy successive slots modulo DEPTH, so the store wraps around from the last slot to slot 0.
- R4: A push with `push_break`=1 stores the word with only bit 10 set (0x400), whatever `push_char` holds. A character push stores `push_char` in bits 7:0 and zeros in bits 10:8.
- R5: `empty` goes to 0 on an accepted push and goes to 1 when the occupancy returns to zero.
- R6: An accepted push sets `full` when the occupancy reaches DEPTH, or whenever `full_on_push`=1. A pop with no accepted push in the same cycle clears `full`.
- R7: `rx_irq` is set in the cycle after an accepted push leaves the occupancy equal to `trig_level`.
- R8: `rx_irq` is cleared only by a pop with no accepted push in the same cycle that leaves the occupancy equal to `trig_level` minus one. Other pops leave it unchanged.
- R9: A pop while the store is empty returns the stale word at the read position and changes neither the read position nor the occupancy.
- R10: An accepted push and an effective pop in the same cycle both complete and leave the occupancy unchanged. On an empty store, push plus pop only stores the new word.
- R11: Changing `trig_level` by itself does not change `rx_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: full depth in use, 0: one-word holding mode |
| full_on_push | input | 1 | Forces `full` on every accepted push |
| trig_level | input | $clog2(DEPTH+1) | Occupancy at which the interrupt is raised |
| push_req | input | 1 | Deliver one received item |
| push_break | input | 1 | The delivered item is a line break |
| push_char | input | DATA_W | Received character |
| pop_req | input | 1 | Data-register read strobe |
| pop_word | output | DATA_W+3 | Word at the read position |
| can_accept | output | 1 | Store has room for a new item |
| empty | output | 1 | Empty status flag |
| full | output | 1 | Full status flag |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
The bench builds the block with its default parameters, a depth of 16 words and 8-bit characters, so the 11-bit word puts the break marker at bit 10. A one-word exchange in holding mode leaves the read position at slot 1. The 16-deep fill that follows therefore has to wrap the ring to reach full, and the empty-pop checks that come after it see a known stale word. The trigger is set to 1, 4 and 2 so that the exact-match set, the one-below clear and an untouched level after a trigger change can each be seen at the ports.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  // Slot reached from position rd by stepping ahead n places on a ring of depth entries.
  function automatic int unsigned rxq_slot(input int unsigned rd,
                                           input int unsigned n,
                                           input int unsigned depth);
    return (rd + n) % depth;
  endfunction

  // Number of words the store may hold in the selected mode.
  function automatic int unsigned rxq_limit(input logic en, input int unsigned depth);
    return en ? depth : 1;
  endfunction

endpackage

// File: rtl/rxq_admit.sv
module rxq_admit
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input  logic             fifo_en,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic [CNT_W-1:0] cnt,
  output logic             can_accept,
  output logic             push_acc,
  output logic             pop_eff
);

  logic [CNT_W-1:0] limit;

  always_comb begin
    limit      = CNT_W'(rxq_limit(fifo_en, DEPTH));
    can_accept = (cnt < limit);
    push_acc   = push_req && can_accept;
    pop_eff    = pop_req && (cnt != '0);
  end

endmodule

// File: rtl/rxq_ring.sv
module rxq_ring
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 11,
  parameter int CNT_W  = 5,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_acc,
  input  logic              pop_eff,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word,
  output logic [PTR_W-1:0]  rd_pos,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cnt_nxt
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_slot;
  logic [PTR_W-1:0]  rd_step;

  always_comb begin
    wr_slot = PTR_W'(rxq_slot(32'(rd_pos), 32'(cnt), DEPTH));
    rd_step = PTR_W'(rxq_slot(32'(rd_pos), 1, DEPTH));
    cnt_nxt = cnt;
    if (push_acc && !pop_eff) cnt_nxt = cnt + CNT_W'(1);
    if (pop_eff && !push_acc) cnt_nxt = cnt - CNT_W'(1);
  end

  assign rd_word = mem[rd_pos];

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_slot] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pos <= '0;
      cnt    <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (pop_eff) rd_pos <= rd_step;
    end
  end

endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_acc,
  input  logic             pop_req,
  input  logic             pop_eff,
  input  logic             full_on_push,
  input  logic [CNT_W-1:0] trig_level,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             empty,
  output logic             full,
  output logic             rx_irq
);

  localparam logic [CNT_W-1:0] TOP = CNT_W'(DEPTH);

  logic [CNT_W-1:0] trig_below;
  logic             irq_set;
  logic             irq_clr;

  always_comb begin
    trig_below = trig_level - CNT_W'(1);
    irq_set    = push_acc && (cnt_nxt == trig_level);
    irq_clr    = pop_eff && !push_acc && (cnt_nxt == trig_below);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty  <= 1'b1;
      full   <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      if (push_acc) begin
        empty <= 1'b0;
        full  <= (cnt_nxt == TOP) || full_on_push;
      end else if (pop_req) begin
        full  <= 1'b0;
        empty <= (cnt_nxt == '0);
      end
      if (irq_set)      rx_irq <= 1'b1;
      else if (irq_clr) rx_irq <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter  int DEPTH  = 16,
  parameter  int DATA_W = 8,
  localparam int WORD_W = DATA_W + 3,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              full_on_push,
  input  logic [CNT_W-1:0]  trig_level,
  input  logic              push_req,
  input  logic              push_break,
  input  logic [DATA_W-1:0] push_char,
  input  logic              pop_req,
  output logic [WORD_W-1:0] pop_word,
  output logic              can_accept,
  output logic              empty,
  output logic              full,
  output logic              rx_irq
);

  logic              push_acc;
  logic              pop_eff;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [PTR_W-1:0]  rd_pos;
  logic [WORD_W-1:0] wr_word;

  // Break marker sits in the top bit with the data field cleared.
  always_comb begin
    wr_word = '0;
    if (push_break) wr_word[WORD_W-1] = 1'b1;
    else            wr_word[DATA_W-1:0] = push_char;
  end

  rxq_admit #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_admit (
    .fifo_en    (fifo_en),
    .push_req   (push_req),
    .pop_req    (pop_req),
    .cnt        (cnt),
    .can_accept (can_accept),
    .push_acc   (push_acc),
    .pop_eff    (pop_eff)
  );

  rxq_ring #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_acc (push_acc),
    .pop_eff  (pop_eff),
    .wr_word  (wr_word),
    .rd_word  (pop_word),
    .rd_pos   (rd_pos),
    .cnt      (cnt),
    .cnt_nxt  (cnt_nxt)
  );

  rxq_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_acc     (push_acc),
    .pop_req      (pop_req),
    .pop_eff      (pop_eff),
    .full_on_push (full_on_push),
    .trig_level   (trig_level),
    .cnt_nxt      (cnt_nxt),
    .empty        (empty),
    .full         (full),
    .rx_irq       (rx_irq)
  );

endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             pop_req,
  input logic             can_accept,
  input logic             empty,
  input logic             full,
  input logic             rx_irq,
  input logic             push_acc,
  input logic             pop_eff,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cnt_nxt,
  input logic [PTR_W-1:0] rd_pos,
  input logic [CNT_W-1:0] trig_level
);

  logic [CNT_W-1:0] trig_m1;
  assign trig_m1 = trig_level - CNT_W'(1);

  a_r2_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  a_r2_single_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && cnt != '0) |-> !can_accept);

  a_r5_empty_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (cnt == '0));

  a_r6_full_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !empty);

  a_r7_irq_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && cnt_nxt == trig_level) |=> rx_irq);

  a_r8_irq_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && pop_eff && !push_acc && cnt_nxt != trig_m1) |=> rx_irq);

  a_r9_empty_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt == '0) |=> $stable(rd_pos));

  a_r10_both_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && pop_eff) |=> $stable(cnt));

endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_en    (fifo_en),
  .pop_req    (pop_req),
  .can_accept (can_accept),
  .empty      (empty),
  .full       (full),
  .rx_irq     (rx_irq),
  .push_acc   (push_acc),
  .pop_eff    (pop_eff),
  .cnt        (cnt),
  .cnt_nxt    (cnt_nxt),
  .rd_pos     (rd_pos),
  .trig_level (trig_level)
);

// File: tb/uart_rx_queue_tb.sv
module uart_rx_queue_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int DATA_W = 8;
  localparam int WORD_W = DATA_W + 3;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0;
  logic full_on_push = 1'b0;
  logic [CNT_W-1:0] trig_level = CNT_W'(1);
  logic push_req = 1'b0;
  logic push_break = 1'b0;
  logic [DATA_W-1:0] push_char = '0;
  logic pop_req = 1'b0;
  logic [WORD_W-1:0] pop_word;
  logic can_accept, empty, full, rx_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .full_on_push(full_on_push),
    .trig_level(trig_level), .push_req(push_req), .push_break(push_break),
    .push_char(push_char), .pop_req(pop_req), .pop_word(pop_word),
    .can_accept(can_accept), .empty(empty), .full(full), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle from a falling edge; the head word is captured before the rising edge.
  task automatic step(input logic p, input logic b, input logic [DATA_W-1:0] c,
                      input logic r, output logic [WORD_W-1:0] got);
    push_req = p; push_break = b; push_char = c; pop_req = r;
    #1 got = pop_word;
    @(posedge clk);
    @(negedge clk);
    push_req = 1'b0; push_break = 1'b0; pop_req = 1'b0;
    #1;
  endtask

  task automatic push_c(input logic [DATA_W-1:0] c);
    logic [WORD_W-1:0] g;
    step(1'b1, 1'b0, c, 1'b0, g);
  endtask

  task automatic pop_w(output logic [WORD_W-1:0] got);
    step(1'b0, 1'b0, '0, 1'b1, got);
  endtask

  task automatic t_reset;
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "rx_irq", rx_irq, 0);
    chk("R1", "can_accept", can_accept, 1);
  endtask

  task automatic t_holding;
    logic [WORD_W-1:0] g;
    fifo_en = 1'b0;
    push_c(8'h41);
    chk("R2", "can_accept one-word", can_accept, 0);
    chk("R7", "irq at trig 1", rx_irq, 1);
    chk("R5", "empty after push", empty, 0);
    push_c(8'h42);
    pop_w(g);
    chk("R2", "dropped push left head", g, 'h041);
    chk("R5", "empty after drain", empty, 1);
    chk("R8", "irq cleared at 0", rx_irq, 0);
    chk("R2", "can_accept after pop", can_accept, 1);
  endtask

  task automatic t_fill;
    logic [WORD_W-1:0] g;
    fifo_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      push_c(DATA_W'(8'h10 + i));
      if (i == DEPTH - 2) chk("R6", "full at 15", full, 0);
    end
    chk("R6", "full at 16", full, 1);
    chk("R2", "can_accept at 16", can_accept, 0);
    push_c(8'hEE);
    for (int i = 0; i < DEPTH; i++) begin
      pop_w(g);
      chk("R3", "order with wrap", g, 'h10 + i);
      if (i == 0) chk("R6", "full cleared by pop", full, 0);
    end
    chk("R5", "empty after drain", empty, 1);
  endtask

  task automatic t_empty_pop;
    logic [WORD_W-1:0] g;
    pop_w(g);
    chk("R9", "stale word", g, 'h010);
    pop_w(g);
    chk("R9", "stale word again", g, 'h010);
    chk("R9", "still empty", empty, 1);
    chk("R9", "still accepts", can_accept, 1);
  endtask

  task automatic t_break;
    logic [WORD_W-1:0] g;
    step(1'b1, 1'b1, 8'h5A, 1'b0, g);
    push_c(8'hFF);
    pop_w(g);
    chk("R4", "break word", g, 1 << 10);
    pop_w(g);
    chk("R4", "char word", g, 'h0FF);
  endtask

  task automatic t_trigger;
    logic [WORD_W-1:0] g;
    trig_level = CNT_W'(4);
    for (int i = 0; i < 3; i++) push_c(DATA_W'(i));
    chk("R7", "no irq at 3", rx_irq, 0);
    push_c(8'h03);
    chk("R7", "irq at 4", rx_irq, 1);
    push_c(8'h04);
    chk("R7", "irq held at 5", rx_irq, 1);
    pop_w(g);
    chk("R8", "no clear at 4", rx_irq, 1);
    pop_w(g);
    chk("R8", "clear at 3", rx_irq, 0);
    push_c(8'h05);
    chk("R7", "set again at 4", rx_irq, 1);
    trig_level = CNT_W'(2);
    @(negedge clk); #1;
    chk("R11", "trigger change keeps irq", rx_irq, 1);
    pop_w(g);
    pop_w(g);
    chk("R8", "no clear at 2", rx_irq, 1);
    pop_w(g);
    chk("R8", "clear at 1", rx_irq, 0);
    trig_level = CNT_W'(1);
    @(negedge clk); #1;
    chk("R11", "trigger change keeps low", rx_irq, 0);
    pop_w(g);
    chk("R5", "drained", empty, 1);
  endtask

  task automatic t_force_full;
    logic [WORD_W-1:0] g;
    full_on_push = 1'b1;
    push_c(8'h66);
    chk("R6", "forced full", full, 1);
    chk("R2", "room remains", can_accept, 1);
    full_on_push = 1'b0;
    pop_w(g);
    chk("R6", "pop clears forced full", full, 0);
    chk("R5", "empty after pop", empty, 1);
  endtask

  task automatic t_both;
    logic [WORD_W-1:0] g;
    push_c(8'hA1);
    push_c(8'hA2);
    step(1'b1, 1'b0, 8'hA3, 1'b1, g);
    chk("R10", "combined pop head", g, 'h0A1);
    chk("R10", "irq kept", rx_irq, 1);
    pop_w(g);
    chk("R10", "second word", g, 'h0A2);
    chk("R10", "one left", empty, 0);
    pop_w(g);
    chk("R10", "third word", g, 'h0A3);
    chk("R10", "count held at 2", empty, 1);
    chk("R8", "irq clear at 0", rx_irq, 0);
    step(1'b1, 1'b0, 8'hB7, 1'b1, g);
    chk("R10", "empty combined stores", empty, 0);
    chk("R7", "empty combined irq", rx_irq, 1);
    pop_w(g);
    chk("R10", "stored word", g, 'h0B7);
    chk("R10", "empty again", empty, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_holding();
    t_fill();
    t_empty_pop();
    t_break();
    t_trigger();
    t_force_full();
    t_both();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule